// File: doc/BRIEF.md
# Receive Interrupt Moderation Controller

This block sits behind the receive write path of a network interface and turns "a frame has landed in host memory" into interrupt cause pulses. When a frame completes with its end-of-packet condition met, it can start or restart a per-frame delay timer and start a fixed-window absolute delay timer. It can raise a timer cause at once when both delays are off. It also raises a small-frame cause from the frame length and a ring-low cause from the number of receive descriptors still free.

A second output asks the descriptor engine to write finished descriptors back to memory. It fires whenever a placement finishes with the ring exhausted or the receive FIFO drained. Both timers count a slow moderation tick supplied from outside, so one delay unit equals one tick period. Masking of causes and register access live elsewhere; the block takes its settings as plain inputs.

Top module: `rxim_ctrl`

## Requirements
- R1: Interrupt causes (timer, small-frame, ring-low) are evaluated only on a `frame_done` cycle with `frame_eop` high; a `frame_done` with `frame_eop` low raises none of them and starts no timer.
- R2: With `pkt_dly` nonzero, every qualifying frame (re)loads the per-frame timer with `pkt_dly`. `rxt_irq` pulses for one cycle when the timer has seen `pkt_dly` ticks since its most recent load. The edge that captures the frame is the load edge, and the pulse becomes visible at the edge of the last tick.
- R3: With `abs_dly` nonzero, a qualifying frame loads the absolute timer only when it is idle. Frames arriving while it runs do not move its expiry, which likewise raises a one-cycle `rxt_irq`.
- R4: With `pkt_dly` and `abs_dly` both zero, a qualifying frame raises `rxt_irq` in the cycle after the capturing edge. With either delay nonzero, no immediate pulse is raised.
- R5: A qualifying frame with `frame_len` <= `small_thr` raises `small_irq` in the cycle after the capturing edge, including at equality.
- R6: A qualifying frame raises `low_irq` in the cycle after the capturing edge when `desc_left` is at or below a fraction of `ring_len` picked by `low_sel`. The codes are 0 = one half (`2*desc_left <= ring_len`), 1 = one quarter (`4*desc_left <= ring_len`) and 2 = one eighth (`8*desc_left <= ring_len`). Code 3 never fires.
- R7: Any `frame_done`, partial or final, raises `wb_req` in the cycle after the capturing edge when `desc_left` is zero or `fifo_empty` is high.
- R8: Timer counts advance only on edges where `mod_tick` is high; with `mod_tick` low a running timer holds.
- R9: Setting a delay input to zero while its timer runs stops that timer, and no `rxt_irq` is raised for it.
- R10: During and directly after reset all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_tick | input | 1 | Moderation time-base enable, one delay unit per high cycle |
| frame_done | input | 1 | A placement into host buffers finished this cycle |
| frame_eop | input | 1 | The finished placement completed the whole frame |
| frame_len | input | LEN_W | Length of the frame in bytes |
| fifo_empty | input | 1 | Receive FIFO holds no further frames |
| desc_left | input | DESC_W | Free descriptors remaining in the ring |
| ring_len | input | DESC_W | Total descriptors in the ring |
| pkt_dly | input | DLY_W | Per-frame (restarting) delay in ticks, 0 = off |
| abs_dly | input | DLY_W | Absolute (non-restarting) delay in ticks, 0 = off |
| small_thr | input | LEN_W | Small-frame length threshold |
| low_sel | input | 2 | Ring-low fraction select |
| rxt_irq | output | 1 | Receive timer cause pulse |
| small_irq | output | 1 | Small-frame cause pulse |
| low_irq | output | 1 | Ring-low cause pulse |
| wb_req | output | 1 | Descriptor write-back request pulse |

## Verification
The bench drives single frames with both delays off, which tells the immediate cause apart from the timer path. It drives frame pairs two cycles apart under each delay alone, and the expiry cycle then shows whether the second frame restarted the per-frame timer or left the absolute timer untouched. Length sweeps below, at and above the threshold, and free-descriptor counts on either side of each fraction, separate the comparison codes and catch off-by-one bounds. Partial placements with the FIFO empty, a stalled tick, and a delay cleared mid-count show that write-back still happens while causes, counting and expiry are suppressed.

// File: rtl/rxim_pkg.sv
package rxim_pkg;

   typedef enum logic [1:0] {
      LOW_HALF    = 2'd0,
      LOW_QUARTER = 2'd1,
      LOW_EIGHTH  = 2'd2,
      LOW_OFF     = 2'd3
   } low_sel_e;

   localparam int NUM_TIMERS = 2;
   localparam int TMR_PKT    = 0;   // restarting
   localparam int TMR_ABS    = 1;   // non-restarting

endpackage

// File: rtl/rxim_delay_timer.sv
module rxim_delay_timer #(
   parameter int W       = 8,
   parameter bit RESTART = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         start,
   input  logic [W-1:0] dly,
   output logic         fire,
   output logic         running
);

   if (W < 1) begin : g_bad_w
      $error("rxim_delay_timer: W must be at least 1");
   end

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt;
   logic         run;
   logic         dly_on;
   logic         load;

   assign dly_on = (dly != '0);

   if (RESTART) begin : g_restart
      assign load = start && dly_on;
   end else begin : g_fixed
      assign load = start && dly_on && !run;
   end

   assign fire    = run && dly_on && tick && (cnt == ONE) && !load;
   assign running = run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (!dly_on) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (load) begin
         run <= 1'b1;
         cnt <= dly;
      end else if (fire) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (run && tick) begin
         cnt <= cnt - ONE;
      end
   end

   AST_RUN_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt != '0)); // R2

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (run && dly_on && !tick && !start) |=> ($stable(cnt) && run)); // R8

   AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!dly_on) |=> !run); // R9

   if (RESTART) begin : g_ast_restart
      AST_PKT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (start && dly_on) |=> (run && cnt == $past(dly))); // R2
   end else begin : g_ast_fixed
      AST_ABS_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
         (run && dly_on) |=> (cnt <= $past(cnt))); // R3
   end

endmodule

// File: rtl/rxim_low_cmp.sv
module rxim_low_cmp
   import rxim_pkg::*;
#(
   parameter int DESC_W = 12
) (
   input  logic [1:0]        sel,
   input  logic [DESC_W-1:0] desc_left,
   input  logic [DESC_W-1:0] ring_len,
   output logic              hit
);

   if (DESC_W < 2) begin : g_bad_w
      $error("rxim_low_cmp: DESC_W must be at least 2");
   end

   localparam int XW = DESC_W + 3;

   logic [XW-1:0] d_ext;
   logic [XW-1:0] r_ext;

   assign d_ext = XW'(desc_left);
   assign r_ext = XW'(ring_len);

   always_comb begin
      unique case (low_sel_e'(sel))
         LOW_HALF:    hit = (d_ext << 1) <= r_ext;
         LOW_QUARTER: hit = (d_ext << 2) <= r_ext;
         LOW_EIGHTH:  hit = (d_ext << 3) <= r_ext;
         default:     hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/rxim_ctrl.sv
module rxim_ctrl
   import rxim_pkg::*;
#(
   parameter int DLY_W  = 8,
   parameter int LEN_W  = 14,
   parameter int DESC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_tick,
   input  logic              frame_done,
   input  logic              frame_eop,
   input  logic [LEN_W-1:0]  frame_len,
   input  logic              fifo_empty,
   input  logic [DESC_W-1:0] desc_left,
   input  logic [DESC_W-1:0] ring_len,
   input  logic [DLY_W-1:0]  pkt_dly,
   input  logic [DLY_W-1:0]  abs_dly,
   input  logic [LEN_W-1:0]  small_thr,
   input  logic [1:0]        low_sel,
   output logic              rxt_irq,
   output logic              small_irq,
   output logic              low_irq,
   output logic              wb_req
);

   if (LEN_W < 1 || DLY_W < 1) begin : g_bad_w
      $error("rxim_ctrl: widths must be at least 1");
   end

   logic                  qual;
   logic                  imm;
   logic                  low_hit;
   logic [DLY_W-1:0]      dly_arr  [NUM_TIMERS];
   logic [NUM_TIMERS-1:0] tmr_fire;
   logic [NUM_TIMERS-1:0] tmr_run;

   assign qual = frame_done && frame_eop;
   assign imm  = qual && (pkt_dly == '0) && (abs_dly == '0);

   assign dly_arr[TMR_PKT] = pkt_dly;
   assign dly_arr[TMR_ABS] = abs_dly;

   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
      rxim_delay_timer #(
         .W       (DLY_W),
         .RESTART (i == TMR_PKT)
      ) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (mod_tick),
         .start   (qual),
         .dly     (dly_arr[i]),
         .fire    (tmr_fire[i]),
         .running (tmr_run[i])
      );
   end

   rxim_low_cmp #(.DESC_W(DESC_W)) u_low (
      .sel       (low_sel),
      .desc_left (desc_left),
      .ring_len  (ring_len),
      .hit       (low_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rxt_irq   <= 1'b0;
         small_irq <= 1'b0;
         low_irq   <= 1'b0;
         wb_req    <= 1'b0;
      end else begin
         rxt_irq   <= imm || (|tmr_fire);
         small_irq <= qual && (frame_len <= small_thr);
         low_irq   <= qual && low_hit;
         wb_req    <= frame_done && ((desc_left == '0) || fifo_empty);
      end
   end

   AST_SMALL_NEEDS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      small_irq |-> $past(frame_done && frame_eop)); // R1

   AST_LOW_NEEDS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      low_irq |-> $past(frame_done && frame_eop)); // R1

   AST_WB_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> $past(frame_done)); // R7

   AST_IMM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && frame_eop && pkt_dly == '0 && abs_dly == '0) |=> rxt_irq); // R4

   AST_RXT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      rxt_irq |-> ($past(frame_done && frame_eop) || $past(|tmr_run))); // R2

endmodule

// File: tb/rxim_ctrl_tb.sv
`timescale 1ns/1ps
module rxim_ctrl_tb;

   localparam int DLY_W  = 8;
   localparam int LEN_W  = 14;
   localparam int DESC_W = 12;

   // mask bits: 3 = rxt_irq, 2 = small_irq, 1 = low_irq, 0 = wb_req
   localparam logic [3:0] M_RXT = 4'b1000;
   localparam logic [3:0] M_SML = 4'b0100;
   localparam logic [3:0] M_LOW = 4'b0010;
   localparam logic [3:0] M_WB  = 4'b0001;

   typedef struct {
      int         cyc;
      logic [3:0] mask;
      string      req;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mod_tick = 1'b1;
   logic              frame_done = 1'b0;
   logic              frame_eop = 1'b0;
   logic [LEN_W-1:0]  frame_len = '0;
   logic              fifo_empty = 1'b0;
   logic [DESC_W-1:0] desc_left = 12'd40;
   logic [DESC_W-1:0] ring_len = 12'd64;
   logic [DLY_W-1:0]  pkt_dly = '0;
   logic [DLY_W-1:0]  abs_dly = '0;
   logic [LEN_W-1:0]  small_thr = 14'd64;
   logic [1:0]        low_sel = 2'd0;
   logic              rxt_irq, small_irq, low_irq, wb_req;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   mon_en = 1'b0;
   bit   done = 1'b0;
   exp_t exp_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rxim_ctrl #(.DLY_W(DLY_W), .LEN_W(LEN_W), .DESC_W(DESC_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick),
      .frame_done(frame_done), .frame_eop(frame_eop), .frame_len(frame_len),
      .fifo_empty(fifo_empty), .desc_left(desc_left), .ring_len(ring_len),
      .pkt_dly(pkt_dly), .abs_dly(abs_dly), .small_thr(small_thr),
      .low_sel(low_sel), .rxt_irq(rxt_irq), .small_irq(small_irq),
      .low_irq(low_irq), .wb_req(wb_req)
   );

   task automatic push_exp(input int c, input logic [3:0] m, input string r);
      exp_t e;
      int   pos;
      e.cyc = c; e.mask = m; e.req = r;
      pos = exp_q.size();
      for (int k = 0; k < exp_q.size(); k++) begin
         if (exp_q[k].cyc > c) begin pos = k; break; end
      end
      exp_q.insert(pos, e);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drive one placement at the current negedge, expect mask one cycle later
   task automatic frame(input bit eop, input int len, input int dl,
                        input bit empty, input logic [3:0] m, input string r);
      frame_done = 1'b1;
      frame_eop  = eop;
      frame_len  = LEN_W'(len);
      desc_left  = DESC_W'(dl);
      fifo_empty = empty;
      push_exp(cyc + 1, m, r);
      @(negedge clk);
      frame_done = 1'b0;
      frame_eop  = 1'b0;
      fifo_empty = 1'b0;
      desc_left  = 12'd40;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_en) begin
         logic [3:0] obs;
         obs = {rxt_irq, small_irq, low_irq, wb_req};
         if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
            checks++;
            if (obs !== exp_q[0].mask) begin
               errors++;
               $display("FAIL %s cycle %0d: outputs %b expected %b",
                        exp_q[0].req, cyc, obs, exp_q[0].mask);
            end
            void'(exp_q.pop_front());
         end else if (obs !== 4'b0000) begin
            checks++;
            errors++;
            $display("FAIL unexpected pulse cycle %0d: outputs %b expected 0000", cyc, obs);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         foreach (exp_q[k]) begin
            checks++;
            errors++;
            $display("FAIL %s cycle %0d never compared: outputs ---- expected %b",
                     exp_q[k].req, exp_q[k].cyc, exp_q[k].mask);
         end
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, outputs n/a expected completion");
      finish_run();
   end

   initial begin : stim
      int n;
      wait_cyc(4);
      // R10: outputs low during reset
      checks++;
      if ({rxt_irq, small_irq, low_irq, wb_req} !== 4'b0000) begin
         errors++;
         $display("FAIL R10 in reset: outputs %b expected 0000",
                  {rxt_irq, small_irq, low_irq, wb_req});
      end
      rst_n = 1'b1;
      mon_en = 1'b1;
      push_exp(cyc + 1, 4'b0000, "R10");
      wait_cyc(3);

      // R4 immediate cause, large frame
      frame(1'b1, 100, 40, 1'b0, M_RXT, "R4");
      wait_cyc(2);
      // R5 small frame below and at threshold, one above
      frame(1'b1, 60, 40, 1'b0, M_RXT | M_SML, "R5");
      wait_cyc(1);
      frame(1'b1, 64, 40, 1'b0, M_RXT | M_SML, "R5");
      wait_cyc(1);
      frame(1'b1, 65, 40, 1'b0, M_RXT, "R5");
      wait_cyc(2);

      // R1 partial placement, FIFO empty: only write-back (R7)
      frame(1'b0, 20, 0, 1'b1, M_WB, "R1");
      wait_cyc(2);
      // R7 final frame with ring exhausted, select off (code 3)
      low_sel = 2'd3;
      frame(1'b1, 100, 0, 1'b0, M_RXT | M_WB, "R7");
      wait_cyc(2);

      // R6 ring-low fractions, ring 64
      low_sel = 2'd0;
      frame(1'b1, 100, 32, 1'b0, M_RXT | M_LOW, "R6");
      wait_cyc(1);
      frame(1'b1, 100, 33, 1'b0, M_RXT, "R6");
      wait_cyc(1);
      low_sel = 2'd1;
      frame(1'b1, 100, 16, 1'b0, M_RXT | M_LOW, "R6");
      wait_cyc(1);
      frame(1'b1, 100, 17, 1'b0, M_RXT, "R6");
      wait_cyc(1);
      low_sel = 2'd2;
      frame(1'b1, 100, 8, 1'b0, M_RXT | M_LOW, "R6");
      wait_cyc(1);
      frame(1'b1, 100, 9, 1'b0, M_RXT, "R6");
      wait_cyc(1);
      low_sel = 2'd3;
      frame(1'b1, 100, 1, 1'b0, M_RXT, "R6");
      wait_cyc(3);
      low_sel = 2'd0;

      // R2 per-frame timer with restart
      pkt_dly = 8'd5;
      n = cyc;
      frame(1'b1, 100, 40, 1'b0, 4'b0000, "R4");   // no immediate when delayed
      push_exp(n + 6, 4'b0000, "R2");               // first expiry superseded
      wait_cyc(1);
      n = cyc;                                      // second frame at n
      frame(1'b1, 100, 40, 1'b0, 4'b0000, "R2");
      push_exp(n + 6, M_RXT, "R2");
      push_exp(n + 7, 4'b0000, "R2");
      wait_cyc(10);

      // R1 partial placement does not start a timer
      n = cyc;
      frame(1'b0, 100, 40, 1'b0, 4'b0000, "R1");
      push_exp(n + 6, 4'b0000, "R1");
      wait_cyc(8);
      pkt_dly = 8'd0;
      wait_cyc(1);

      // R3 absolute timer not extended
      abs_dly = 8'd6;
      n = cyc;
      frame(1'b1, 100, 40, 1'b0, 4'b0000, "R3");
      push_exp(n + 7, M_RXT, "R3");
      wait_cyc(1);
      frame(1'b1, 100, 40, 1'b0, 4'b0000, "R3");
      push_exp(n + 9, 4'b0000, "R3");
      wait_cyc(12);
      abs_dly = 8'd0;
      wait_cyc(1);

      // R8 tick stall holds the count
      pkt_dly = 8'd3;
      mod_tick = 1'b0;
      n = cyc;
      frame(1'b1, 100, 40, 1'b0, 4'b0000, "R8");
      push_exp(n + 4, 4'b0000, "R8");
      wait_cyc(3);                                  // now at n+4
      mod_tick = 1'b1;                              // first tick at edge n+5
      push_exp(n + 7, M_RXT, "R8");
      wait_cyc(6);

      // R9 cancel by clearing the delay
      pkt_dly = 8'd10;
      n = cyc;
      frame(1'b1, 100, 40, 1'b0, 4'b0000, "R9");
      wait_cyc(3);
      pkt_dly = 8'd0;
      push_exp(n + 11, 4'b0000, "R9");
      wait_cyc(14);

      // R9 timer usable again afterwards
      pkt_dly = 8'd2;
      n = cyc;
      frame(1'b1, 100, 40, 1'b0, 4'b0000, "R9");
      push_exp(n + 3, M_RXT, "R9");
      wait_cyc(6);

      finish_run();
   end

endmodule